// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on separate clocks. Clocks may be unrelated or may be the same net. A word is accepted on a write-clock edge when a pair of write enables is active. A word is taken on a read-clock edge when a pair of read enables is active. The word that is read appears on a registered output, and an output-enable input can float that output.

Four status flags report the fill level. Empty and almost-empty are produced on the read side. Full and almost-full are produced on the write side. Each pointer crosses to the opposite clock in Gray code through a chain of synchronizer flops. As a result, a flag may follow a change made on the other side a few cycles late, but it never clears early.

The almost-empty and almost-full thresholds live in two offset registers. These are written through the write port: hold the active-low write enable low and pull the second write enable low, and successive write-clock edges load the two registers in turn. The offsets are meant to be loaded while no traffic is flowing.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge when `wr_en_n` is 0 and `wr_ld_en` is 1. Holding both at those values stores a word on every edge.
- R2: A read happens on a rising `rd_clk` edge when `rd_en_n` is 0 and `rd_en` is 1. After that edge, the output register holds the oldest stored word, so words leave in the order they were written.
- R3: A write request while `full` is 1 is dropped. The stored words and the level stay as they were.
- R4: A read request while `empty` is 1 is ignored. The output register keeps its value, and the next word written is the next word read.
- R5: Once both sides have settled, `empty` is 1 exactly when the level is 0, and `full` is 1 exactly when the level equals DEPTH.
- R6: Once settled, `almost_empty` is 1 when the level is at most the empty offset. `almost_full` is 1 when the level is at least DEPTH minus the full offset.
- R7: A `wr_clk` edge with `wr_en_n` = 0 and `wr_ld_en` = 0 loads `wr_data[AW-1:0]` into an offset register and stores no word. The loads alternate: the empty offset first, then the full offset, then the empty offset again.
- R8: With `rst_n` low across rising edges of both clocks, the block ends up empty. After reset, `empty` = 1, `almost_empty` = 1, `full` = 0, `almost_full` = 0, the output register is 0, both offsets are 7, and the next load targets the empty offset.
- R9: When `oe_n` is 1, `rd_data` is high impedance on all bits. When `oe_n` is 0, `rd_data` shows the output register.
- R10: Each pointer that crosses a clock boundary changes by at most one bit per edge of its own clock.
- R11: A write edge with `wr_en_n` = 1 stores nothing, and a read edge with `rd_en` = 0 reads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, free running |
| rd_clk | input | 1 | Read clock, free running |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| wr_data | input | DW | Write word; the low AW bits are also the offset load value |
| wr_en_n | input | 1 | Write enable, active low |
| wr_ld_en | input | 1 | Second write enable when high; selects offset load when low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en | input | 1 | Read enable, active high |
| oe_n | input | 1 | Output enable, active low; high floats `rd_data` |
| rd_data | output | DW | Registered read word, three-state |
| empty | output | 1 | No words held (read domain) |
| almost_empty | output | 1 | Level at or below the empty offset (read domain) |
| full | output | 1 | DEPTH words held (write domain) |
| almost_full | output | 1 | Level at or above DEPTH minus the full offset (write domain) |

## Verification
The hardest situation to reach is the one where both programmable thresholds have been moved away from their reset values and each boundary level is then visited from both directions. The bench first writes the two offsets through the write port. It then fills the buffer one word at a time, from empty all the way to full, and afterwards drains it the same way. After each step it waits for the pointers to cross, then compares all four flags with values computed from the level and the loaded offsets. Overflow and underflow requests are applied exactly at the full and empty levels, and the data that follows them shows that neither pointer moved.

// File: rtl/dcfifo_pkg.sv
// Shared types and helpers for the dual-clock FIFO.
// Assumes pointer widths of at most PTR_MAX bits.
package dcfifo_pkg;
    localparam int PTR_MAX = 16;
    typedef logic [PTR_MAX-1:0] ptr_t;

    // Which offset register the next load writes.
    typedef enum logic {LD_AE = 1'b0, LD_AF = 1'b1} ld_sel_e;

    // Gray to binary conversion on the widest pointer; callers slice.
    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcfifo_ram.sv
// Dual-port storage: one synchronous write port and one combinational read port.
// Assumes the controllers never write a slot that has not yet been read.
module dcfifo_ram #(
    parameter int DW    = 9,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one word per enabled write edge.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer bus.
// Assumes the input changes by at most one bit per source edge.
module dcfifo_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the foreign bus.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    // Later stages settle metastability.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
// Write-domain control: write pointer, full/almost-full flags and offset loading.
// Assumes rgray_s is the read pointer already synchronized into wr_clk.
module dcfifo_wr_ctl #(
    parameter int DEPTH   = 64,
    parameter int OFF_RST = 7,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          wr_ld_en,
    input  logic [AW-1:0] ld_val,
    input  logic [PW-1:0] rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          almost_full,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    import dcfifo_pkg::*;

    logic [PW-1:0] wbin, wbin_nxt, rbin_s, wlevel, af_thr;
    ptr_t          rconv;
    ld_sel_e       ld_sel;
    logic          wr_req, ld_req;

    assign wr_req = !wr_en_n && wr_ld_en;
    assign ld_req = !wr_en_n && !wr_ld_en;

    // Level seen from the write side, using the lagging read pointer.
    always_comb begin
        rconv       = gray2bin(ptr_t'(rgray_s));
        rbin_s      = rconv[PW-1:0];
        wlevel      = wbin - rbin_s;
        af_thr      = PW'(DEPTH) - {1'b0, af_off};
        full        = (wlevel == PW'(DEPTH));
        almost_full = (wlevel >= af_thr);
        mem_we      = wr_req && !full;
        wbin_nxt    = wbin + PW'(mem_we);
    end

    assign waddr = wbin[AW-1:0];

    // Advance the binary and Gray write pointers together.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Load offsets alternately: empty offset, then full offset.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ae_off <= AW'(OFF_RST);
            af_off <= AW'(OFF_RST);
            ld_sel <= LD_AE;
        end else if (ld_req) begin
            if (ld_sel == LD_AE) begin
                ae_off <= ld_val;
                ld_sel <= LD_AF;
            end else begin
                af_off <= ld_val;
                ld_sel <= LD_AE;
            end
        end
    end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
// Read-domain control: read pointer and empty/almost-empty flags.
// Assumes wgray_s is synchronized into rd_clk and ae_off is quasi-static.
module dcfifo_rd_ctl #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ae_off,
    output logic          rd_fire,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          almost_empty
);
    import dcfifo_pkg::*;

    logic [PW-1:0] rbin, rbin_nxt, wbin_s, rlevel;
    ptr_t          wconv;

    // Level seen from the read side, using the lagging write pointer.
    always_comb begin
        wconv        = gray2bin(ptr_t'(wgray_s));
        wbin_s       = wconv[PW-1:0];
        rlevel       = wbin_s - rbin;
        empty        = (rlevel == '0);
        almost_empty = (rlevel <= {1'b0, ae_off});
        rd_fire      = !rd_en_n && rd_en && !empty;
        rbin_nxt     = rbin + PW'(rd_fire);
    end

    assign raddr = rbin[AW-1:0];

    // Advance the binary and Gray read pointers together.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end
endmodule

// File: rtl/dcfifo_pflag.sv
// Top of the dual-clock FIFO: storage, two pointer crossings, both
// controllers and the registered three-state output.
// Assumes rst_n is held low across edges of both clocks.
module dcfifo_pflag #(
    parameter int DW      = 9,
    parameter int DEPTH   = 64,
    parameter int OFF_RST = 7,
    parameter int STAGES  = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en_n,
    input  logic          wr_ld_en,
    input  logic          rd_en_n,
    input  logic          rd_en,
    input  logic          oe_n,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty,
    output logic          full,
    output logic          almost_full
);
    logic          mem_we, rd_fire;
    logic [AW-1:0] waddr, raddr, ae_off, af_off;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [DW-1:0] mem_rdata, rd_q;

    dcfifo_ram #(.DW(DW), .DEPTH(DEPTH)) ram_i (
        .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dcfifo_wr_ctl #(.DEPTH(DEPTH), .OFF_RST(OFF_RST)) wr_ctl_i (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_ld_en(wr_ld_en),
        .ld_val(wr_data[AW-1:0]), .rgray_s(rgray_s), .mem_we(mem_we),
        .waddr(waddr), .wgray(wgray), .full(full), .almost_full(almost_full),
        .ae_off(ae_off), .af_off(af_off)
    );

    dcfifo_rd_ctl #(.DEPTH(DEPTH)) rd_ctl_i (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rd_en(rd_en),
        .wgray_s(wgray_s), .ae_off(ae_off), .rd_fire(rd_fire), .raddr(raddr),
        .rgray(rgray), .empty(empty), .almost_empty(almost_empty)
    );

    dcfifo_sync #(.W(PW), .STAGES(STAGES)) w2r_i (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcfifo_sync #(.W(PW), .STAGES(STAGES)) r2w_i (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    // Capture the oldest word into the output register on each read.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_fire) rd_q <= mem_rdata;
    end

    assign rd_data = oe_n ? {DW{1'bz}} : rd_q;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
// Property checker bound to dcfifo_pflag; observes pointers and flags only.
module dcfifo_pflag_chk #(
    parameter int DW    = 9,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          wr_ld_en,
    input logic          rd_en_n,
    input logic          rd_en,
    input logic          empty,
    input logic          almost_empty,
    input logic          full,
    input logic          almost_full,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray,
    input logic [PW-1:0] rgray_s,
    input logic [DW-1:0] rd_q
);
    import dcfifo_pkg::*;

    logic [PW-1:0] wb, rb, wlvl;
    ptr_t          wc, rc;
    logic          wr_req, rd_req;

    // Level as the write side sees it, rebuilt from Gray pointers.
    always_comb begin
        wc     = gray2bin(ptr_t'(wgray));
        rc     = gray2bin(ptr_t'(rgray_s));
        wb     = wc[PW-1:0];
        rb     = rc[PW-1:0];
        wlvl   = wb - rb;
        wr_req = !wr_en_n && wr_ld_en;
        rd_req = !rd_en_n && rd_en;
    end

    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wlvl <= PW'(DEPTH));

    assert_full_hold_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_req) |=> $stable(wgray));

    assert_empty_hold_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_req) |=> ($stable(rgray) && $stable(rd_q)));

    assert_empty_nests_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    assert_full_nests_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);

    assert_wgray_step_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> $onehot0(wgray ^ $past(wgray)));

    assert_rgray_step_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        1'b1 |=> $onehot0(rgray ^ $past(rgray)));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_ld_en(wr_ld_en), .rd_en_n(rd_en_n), .rd_en(rd_en),
    .empty(empty), .almost_empty(almost_empty), .full(full),
    .almost_full(almost_full), .wgray(wgray), .rgray(rgray),
    .rgray_s(rgray_s), .rd_q(rd_q)
);

// File: tb/dcfifo_pflag_tb_top.sv
// Level sweeps over a 16-deep FIFO with an arithmetic model of level and flags.
module dcfifo_pflag_tb_top;
    localparam int DEPTH = 16;

    logic       wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic [8:0] wr_data = '0;
    logic       wr_en_n = 1, wr_ld_en = 1, rd_en_n = 1, rd_en = 0, oe_n = 0;
    wire  [8:0] rd_data;
    wire        empty, almost_empty, full, almost_full;

    int passed = 0, total = 0;
    int lvl = 0, ae_o = 7, af_o = 7;

    always #4 wr_clk = ~wr_clk;
    always #6 rd_clk = ~rd_clk;

    dcfifo_pflag #(.DW(9), .DEPTH(DEPTH)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en_n(wr_en_n), .wr_ld_en(wr_ld_en), .rd_en_n(rd_en_n), .rd_en(rd_en),
        .oe_n(oe_n), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
        .full(full), .almost_full(almost_full)
    );

    function automatic logic [8:0] pat(int i);
        return 9'((i * 37 + 5) % 512);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge rd_clk);
        repeat (5) @(negedge wr_clk);
    endtask

    task automatic chk_flags();
        chk(empty == (lvl == 0), "R5 empty", int'(empty), int'(lvl == 0));
        chk(full == (lvl == DEPTH), "R5 full", int'(full), int'(lvl == DEPTH));
        chk(almost_empty == (lvl <= ae_o), "R6 almost_empty",
            int'(almost_empty), int'(lvl <= ae_o));
        chk(almost_full == (lvl >= DEPTH - af_o), "R6 almost_full",
            int'(almost_full), int'(lvl >= DEPTH - af_o));
    endtask

    task automatic do_write(input logic [8:0] d);
        @(negedge wr_clk);
        wr_data = d; wr_en_n = 0; wr_ld_en = 1;
        @(negedge wr_clk);
        wr_en_n = 1;
    endtask

    task automatic do_load(input int v);
        @(negedge wr_clk);
        wr_data = 9'(v); wr_en_n = 0; wr_ld_en = 0;
        @(negedge wr_clk);
        wr_en_n = 1; wr_ld_en = 1;
    endtask

    task automatic do_read();
        @(negedge rd_clk);
        rd_en_n = 0; rd_en = 1;
        @(negedge rd_clk);
        rd_en_n = 1; rd_en = 0;
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst_n = 0;
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
        rst_n = 1;
        lvl = 0; ae_o = 7; af_o = 7;
        settle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1000000;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R8: reset state
        do_reset();
        chk_flags();
        chk(rd_data === 9'd0, "R8 rd_data", int'(rd_data), 0);

        // R11: write edges with wr_en_n high store nothing
        @(negedge wr_clk);
        wr_data = 9'h1F0; wr_en_n = 1; wr_ld_en = 1;
        repeat (3) @(negedge wr_clk);
        settle();
        chk(empty == 1'b1, "R11 no write", int'(empty), 1);

        // R1/R5/R6: fill sweep with default offsets
        for (int i = 0; i < DEPTH; i++) begin
            do_write(pat(i));
            lvl++;
            settle();
            chk_flags();
        end

        // R3: write while full is dropped
        do_write(9'h1AA);
        settle();
        chk_flags();

        // R11: read edges with rd_en low read nothing
        @(negedge rd_clk);
        rd_en_n = 0; rd_en = 0;
        repeat (3) @(negedge rd_clk);
        rd_en_n = 1;
        settle();
        chk(full == 1'b1, "R11 no read full", int'(full), 1);
        chk(rd_data === 9'd0, "R11 no read data", int'(rd_data), 0);

        // R2/R5/R6: drain sweep, order preserved, dropped word absent (R3)
        for (int i = 0; i < DEPTH; i++) begin
            do_read();
            chk(rd_data === pat(i), "R2 order", int'(rd_data), int'(pat(i)));
            lvl--;
            settle();
            chk_flags();
        end

        // R4: read while empty ignored
        do_read();
        chk(rd_data === pat(DEPTH - 1), "R4 hold", int'(rd_data), int'(pat(DEPTH - 1)));
        settle();
        chk_flags();
        do_write(9'h055);
        settle();
        do_read();
        chk(rd_data === 9'h055, "R4 pointer", int'(rd_data), 9'h055);
        settle();

        // R9: output enable
        @(negedge rd_clk);
        oe_n = 1;
        #1;
        chk(rd_data === 9'bz, "R9 float", int'(rd_data), 0);
        oe_n = 0;
        #1;
        chk(rd_data === 9'h055, "R9 drive", int'(rd_data), 9'h055);

        // R7: load offsets, no word stored, sweep both ways
        do_load(3); ae_o = 3;
        do_load(2); af_o = 2;
        settle();
        chk(empty == 1'b1, "R7 load stores nothing", int'(empty), 1);
        chk_flags();
        for (int i = 0; i < DEPTH; i++) begin
            do_write(pat(i + 40));
            lvl++;
            settle();
            chk_flags();
        end
        for (int i = 0; i < DEPTH; i++) begin
            do_read();
            chk(rd_data === pat(i + 40), "R7 data", int'(rd_data), int'(pat(i + 40)));
            lvl--;
            settle();
            chk_flags();
        end
        // R7: third load goes to the empty offset again
        do_load(5); ae_o = 5;
        settle();
        for (int i = 0; i < 7; i++) begin
            do_write(pat(i));
            lvl++;
            settle();
            chk_flags();
        end

        // R8: reset mid-fill restores empty state and offsets of 7
        do_reset();
        chk_flags();
        chk(rd_data === 9'd0, "R8 rd_data again", int'(rd_data), 0);
        for (int i = 0; i < 10; i++) begin
            do_write(pat(i + 90));
            lvl++;
            settle();
            chk_flags();
        end
        do_load(1); ae_o = 1;
        settle();
        chk(almost_empty == 1'b0, "R8 load targets empty offset", int'(almost_empty), 0);
        chk_flags();

        finish_run();
    end
endmodule